// File: doc/BRIEF.md
# Horizontal Half-Field Combine Unit

The unit takes a single N-bit vector and a selected field width n, where n is a power of two. It splits the vector into N/n fields. Inside each field, the upper n/2 bits and the lower n/2 bits are both zero-extended to n bits. The two values are then combined by addition or by exclusive-or, and the n-bit result is written back into the same field position. The output vector therefore has N bits, just like the input.

Repeated passes at widths 2, 4, 8 and so on build wider reductions out of narrower ones. Three add passes at widths 2, 4 and 8 give a population count per byte. Two xor passes at widths 2 and 4 give the parity of each nibble.

The width is selected as log2(n). A select outside the range 1..log2(N) passes the input through unchanged. The result and its valid flag are registered, so each output appears one cycle after its input.

Top module: `hfc_unit`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_vec` is all zeros.
- R2: `out_valid` equals the value `in_valid` had one cycle earlier.
- R3: When `op_sel`=0 (add) and `width_log2`=k with 1<=k<=log2(N), each output field j of n=2^k bits equals upper half plus lower half of input field j. Field j occupies bits [j*n+n-1 : j*n], the upper half is the top n/2 bits and the lower half is the bottom n/2 bits.
- R4: When `op_sel`=1 (xor) and k is in range, each output field is the upper half xor the lower half, zero-extended to n bits. The top n/2 bits of every field are therefore 0.
- R5: At k=1 with add, each 2-bit output field is the sum of the two adjacent input bits, a value from 0 to 2.
- R6: An add result never overflows. For k>=2 the top n/2-1 bits of every output field are 0.
- R7: When `width_log2` is 0 or greater than log2(N), `out_vec` equals the input vector of the previous cycle.
- R8: When `in_valid` is 0, `out_vec` holds its previous value.
- R9: Add passes at k=1, 2 and 3, applied in sequence, give the population count of each byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input vector is valid |
| in_vec | input | VEC_W | Input vector |
| width_log2 | input | SEL_W | log2 of the target field width |
| op_sel | input | 1 | 0 = add, 1 = xor |
| out_valid | output | 1 | Registered valid |
| out_vec | output | VEC_W | Registered result |

## Verification
A wrong field boundary or a swapped half shows up on `out_vec` one cycle after the offending input. The bench's reference model computes every field from integers, so a mismatch in any single field is reported on the very next clock. A stuck or shifted valid register shows up as an `out_valid` mismatch in that same cycle. Chained passes check that results stay correct when one pass feeds the next, which is how population count and parity are built.

// File: rtl/hfc_pkg.sv
package hfc_pkg;
    typedef enum logic {
        HFC_ADD = 1'b0,
        HFC_XOR = 1'b1
    } hfc_op_e;
endpackage

// File: rtl/hfc_lane.sv
module hfc_lane #(
    parameter int FW = 4
) (
    input  logic          op_xor,
    input  logic [FW-1:0] fin,
    output logic [FW-1:0] fout
);
    localparam int HW = FW / 2;
    logic [FW-1:0] hi_ext;
    logic [FW-1:0] lo_ext;
    always_comb begin
        hi_ext = {{HW{1'b0}}, fin[FW-1:HW]};
        lo_ext = {{HW{1'b0}}, fin[HW-1:0]};
        fout   = op_xor ? (hi_ext ^ lo_ext) : (hi_ext + lo_ext);
    end
endmodule

// File: rtl/hfc_stage.sv
module hfc_stage #(
    parameter int VEC_W = 32,
    parameter int FW    = 2
) (
    input  logic             op_xor,
    input  logic [VEC_W-1:0] vin,
    output logic [VEC_W-1:0] vout
);
    localparam int NF = VEC_W / FW;
    for (genvar j = 0; j < NF; j++) begin : g_lane
        hfc_lane #(.FW(FW)) u_lane (
            .op_xor(op_xor),
            .fin   (vin[j*FW +: FW]),
            .fout  (vout[j*FW +: FW])
        );
    end
endmodule

// File: rtl/hfc_unit.sv
module hfc_unit
    import hfc_pkg::*;
#(
    parameter int VEC_W = 32,
    parameter int SEL_W = $clog2($clog2(VEC_W) + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] in_vec,
    input  logic [SEL_W-1:0] width_log2,
    input  logic             op_sel,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_vec
);
    localparam int KMAX = $clog2(VEC_W);

    typedef struct packed {
        logic             vld;
        logic [VEC_W-1:0] vec;
    } state_t;

    state_t st_d, st_q;
    logic [VEC_W-1:0] cand [KMAX+1];
    logic             op_xor;

    assign op_xor  = (hfc_op_e'(op_sel) == HFC_XOR);
    assign cand[0] = in_vec;

    for (genvar k = 1; k <= KMAX; k++) begin : g_width
        hfc_stage #(.VEC_W(VEC_W), .FW(1 << k)) u_stage (
            .op_xor(op_xor),
            .vin   (in_vec),
            .vout  (cand[k])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.vec = in_vec;
            for (int k = 1; k <= KMAX; k++) begin
                if (int'(width_log2) == k) st_d.vec = cand[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_vec   = st_q.vec;
endmodule

// File: rtl/hfc_unit_chk.sv
module hfc_unit_chk #(
    parameter int VEC_W = 32,
    parameter int SEL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [VEC_W-1:0] in_vec,
    input logic [SEL_W-1:0] width_log2,
    input logic             op_sel,
    input logic             out_valid,
    input logic [VEC_W-1:0] out_vec
);
    localparam int KMAX = $clog2(VEC_W);
    logic started;
    always_ff @(posedge clk) begin
        if (!rst_n) started <= 1'b0;
        else        started <= 1'b1;
    end

    function automatic logic xor_top_clear(input logic [VEC_W-1:0] v, input int k);
        int n = 1 << k;
        for (int b = 0; b < VEC_W; b++)
            if ((b % n) >= n/2 && v[b]) return 1'b0;
        return 1'b1;
    endfunction

    assert_reset_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> (!out_valid && out_vec == '0));
    assert_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> out_valid == $past(in_valid));
    assert_xor_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel && width_log2 >= 1 && int'(width_log2) <= KMAX)
        |=> xor_top_clear(out_vec, int'($past(width_log2))));
    assert_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (width_log2 == 0 || int'(width_log2) > KMAX))
        |=> out_vec == $past(in_vec));
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (started && !in_valid) |=> $stable(out_vec));
endmodule

bind hfc_unit hfc_unit_chk #(.VEC_W(VEC_W), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/hfc_unit_test.sv
module hfc_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int VEC_W = 32;
    localparam int SEL_W = 3;

    logic clk = 0, rst_n = 0, in_valid = 0, op_sel = 0;
    logic [VEC_W-1:0] in_vec = '0;
    logic [SEL_W-1:0] width_log2 = '0;
    logic out_valid;
    logic [VEC_W-1:0] out_vec;
    int checks = 0, fails = 0;
    logic [VEC_W-1:0] exp_vec = '0;
    logic exp_vld = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hfc_unit #(.VEC_W(VEC_W), .SEL_W(SEL_W)) uut (.*);

    function automatic logic [VEC_W-1:0] model(input logic [VEC_W-1:0] v, input int k, input bit x);
        logic [VEC_W-1:0] r;
        int n, h;
        longint hi, lo;
        if (k < 1 || k > 5) return v;
        n = 1 << k; h = n / 2; r = '0;
        for (int j = 0; j < VEC_W / n; j++) begin
            hi = 0; lo = 0;
            for (int b = 0; b < h; b++) begin
                lo += longint'(v[j*n + b]) << b;
                hi += longint'(v[j*n + h + b]) << b;
            end
            for (int b = 0; b < n; b++) r[j*n + b] = ((x ? (hi ^ lo) : (hi + lo)) >> b) & 1;
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [VEC_W-1:0] act, input logic [VEC_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input bit v, input logic [VEC_W-1:0] d, input int k, input bit x, input string req);
        in_valid = v; in_vec = d; width_log2 = SEL_W'(k); op_sel = x;
        @(posedge clk);
        exp_vld = v;
        if (v) exp_vec = model(d, k, x);
        #1;
        chk({req, " R2 valid"}, {31'b0, out_valid}, {31'b0, exp_vld});
        chk(req, out_vec, exp_vec);
    endtask

    function automatic logic [VEC_W-1:0] popcnt_bytes(input logic [VEC_W-1:0] v);
        logic [VEC_W-1:0] r = '0;
        for (int j = 0; j < 4; j++) r[j*8 +: 8] = 8'($countones(v[j*8 +: 8]));
        return r;
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [VEC_W-1:0] t;
        repeat (2) @(posedge clk);
        #1;
        chk("R1 reset vec", out_vec, '0);
        chk("R1 reset valid", {31'b0, out_valid}, '0);
        rst_n = 1;
        drive(1, 32'h0102_FF80, 4, 0, "R3 add n16");
        drive(1, 32'hFFFF_FFFF, 4, 0, "R6 add no overflow");
        drive(1, 32'hF0A5_3C99, 3, 0, "R3 add n8");
        drive(1, 32'hDEAD_BEEF, 5, 0, "R3 add n32");
        drive(1, 32'hFFFF_0000, 1, 0, "R5 add n2");
        drive(1, 32'hA5A5_1234, 2, 1, "R4 xor n4");
        drive(1, 32'hCAFE_F00D, 5, 1, "R4 xor n32");
        drive(1, 32'h1357_9BDF, 0, 0, "R7 pass k0");
        drive(1, 32'h2468_ACE0, 6, 1, "R7 pass k6");
        drive(1, 32'h2468_ACE0, 7, 0, "R7 pass k7");
        drive(0, 32'h1111_1111, 3, 0, "R8 hold");
        drive(0, 32'h0000_0000, 1, 1, "R8 hold 2");
        for (int i = 0; i < 200; i++) drive(1, $urandom, ($urandom % 8), $urandom % 2, "R3/R4 sweep");
        t = 32'hB7_01_FF_00;
        drive(1, t, 1, 0, "R9 step1");
        drive(1, out_vec, 2, 0, "R9 step2");
        drive(1, out_vec, 3, 0, "R9 step3");
        chk("R9 popcount", out_vec, popcnt_bytes(t));
        t = 32'h9E37_79B9;
        drive(1, t, 1, 1, "R4 parity step1");
        drive(1, out_vec, 2, 1, "R4 parity step2");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule